// File: doc/BRIEF.md
# Serial-Programmed Output Enable Controller

This block is the programming logic for a one-to-ten clock fan-out buffer. It takes a programming clock, a serial data line and an active-high program enable. It drives ten output-enable bits and one clock-input select bit into the fan-out datapath. It does not touch the clock path itself.

A rising edge on the program enable opens a programming sequence. The next eleven rising edges of the programming clock shift in a configuration word, starting with bit 0. The twelfth edge commits that word to the control register. Once committed, the setting holds while the enable stays high, and later clock edges change nothing. While the enable is low, the registers are held in reset. In that state every output is enabled and the serial data line selects the clock input directly, so a board that never programs the block still works. The enable also acts as the asynchronous active-low reset of the programming-clock domain.

Top module: `fanout_prog_ctrl`

## Requirements
- R1: While the enable is high, serial data is sampled on each rising programming-clock edge, and the word arrives least-significant bit first: the first sampled bit is word bit 0 and the eleventh is word bit 10.
- R2: Word bits 0 to 9 are output enables in reversed order: word bit k drives `oe_o[9-k]`. A 1 enables the output and a 0 disables it.
- R3: Word bit 10 is the clock select driven on `clk_sel_o`. A 0 selects clock input 0 and a 1 selects clock input 1.
- R4: The word appears on the outputs after the twelfth rising edge that follows the enable's rise, and not after any earlier edge.
- R5: A rise of the enable resets the control register. From that rise until the commit, the outputs show all ten outputs enabled with clock input 0 selected.
- R6: While the enable is low, `oe_o` is all ones and `clk_sel_o` follows `ser_data_i` combinationally, with no clock edge needed.
- R7: After the commit, further programming-clock edges while the enable stays high leave `oe_o` and `clk_sel_o` unchanged, whatever the serial data.
- R8: Dropping the enable in the middle of a sequence abandons it. The next rise of the enable starts a fresh twelve-edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prog_clk_i | input | 1 | Programming clock; data is sampled on its rising edge |
| prog_en_i | input | 1 | Program enable, active high; when low, it asynchronously resets the programming logic |
| ser_data_i | input | 1 | Serial configuration data; when the enable is low, it is the live clock select |
| oe_o | output | 10 | Per-output enable, 1 = driving, 0 = tristated |
| clk_sel_o | output | 1 | Clock input select, 0 = input 0, 1 = input 1 |

## Verification
A sequence counter that is off by one shows up on the very edge it misfires. An early commit loads a word whose bit 10 is missing, and a late one leaves the all-enabled default in place one clock past the twelfth edge. A broken shift chain or a wrong enable mapping appears as a bit-reversed or rotated `oe_o` at the commit. A counter that does not saturate re-commits shifted data on later edges, so `oe_o` moves within a cycle or two after the commit. A counter that fails to clear while the enable is low corrupts the next sequence, because its commit lands too early.

// File: rtl/fanout_prog_pkg.sv
package fanout_prog_pkg;
  typedef enum logic [1:0] {
    PH_SHIFT  = 2'd0,
    PH_COMMIT = 2'd1,
    PH_DONE   = 2'd2
  } seq_phase_e;
endpackage

// File: rtl/fpc_seq_counter.sv
module fpc_seq_counter
  import fanout_prog_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 12
) (
  input  logic       clk_i,
  input  logic       en_i,
  output seq_phase_e phase_o
);
  localparam int unsigned CNT_W = $clog2(SEQ_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] SAT        = CNT_W'(SEQ_LEN);

  logic [CNT_W-1:0] cnt_q;

  // counts edges since enable rise, holds once the sequence is done
  always_ff @(posedge clk_i or negedge en_i) begin
    if (!en_i)              cnt_q <= '0;
    else if (cnt_q != SAT)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q < LAST_SHIFT)       phase_o = PH_SHIFT;
    else if (cnt_q == LAST_SHIFT) phase_o = PH_COMMIT;
    else                          phase_o = PH_DONE;
  end
endmodule

// File: rtl/fpc_shift_reg.sv
module fpc_shift_reg #(
  parameter int unsigned WIDTH = 11
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             shift_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] stages_o
);
  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge en_i) begin
    if (!en_i)        stage_q[0] <= 1'b0;
    else if (shift_i) stage_q[0] <= sdata_i;
  end

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge en_i) begin
      if (!en_i)        stage_q[i] <= 1'b0;
      else if (shift_i) stage_q[i] <= stage_q[i-1];
    end
  end

  assign stages_o = stage_q;
endmodule

// File: rtl/fpc_ctrl_reg.sv
module fpc_ctrl_reg #(
  parameter int unsigned NUM_OUT = 10,
  localparam int unsigned WORD_W = NUM_OUT + 1
) (
  input  logic               clk_i,
  input  logic               en_i,
  input  logic               commit_i,
  input  logic [WORD_W-1:0]  stages_i,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               sel_o
);
  logic [NUM_OUT-1:0] oe_q;
  logic               sel_q;

  // stage 0 holds the last bit shifted (select); stage j+1 holds the enable for output j
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_oe
    always_ff @(posedge clk_i or negedge en_i) begin
      if (!en_i)         oe_q[j] <= 1'b1;
      else if (commit_i) oe_q[j] <= stages_i[j+1];
    end
  end

  always_ff @(posedge clk_i or negedge en_i) begin
    if (!en_i)         sel_q <= 1'b0;
    else if (commit_i) sel_q <= stages_i[0];
  end

  assign oe_o  = oe_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/fanout_prog_ctrl.sv
module fanout_prog_ctrl
  import fanout_prog_pkg::*;
#(
  parameter int unsigned NUM_OUT = 10
) (
  input  logic               prog_clk_i,
  input  logic               prog_en_i,
  input  logic               ser_data_i,
  output logic [NUM_OUT-1:0] oe_o,
  output logic               clk_sel_o
);
  localparam int unsigned WORD_W  = NUM_OUT + 1;
  localparam int unsigned SEQ_LEN = WORD_W + 1;

  seq_phase_e         phase;
  logic [WORD_W-1:0]  stages;
  logic [NUM_OUT-1:0] reg_oe;
  logic               reg_sel;

  fpc_seq_counter #(.SEQ_LEN(SEQ_LEN)) u_cnt (
    .clk_i   (prog_clk_i),
    .en_i    (prog_en_i),
    .phase_o (phase)
  );

  fpc_shift_reg #(.WIDTH(WORD_W)) u_sr (
    .clk_i    (prog_clk_i),
    .en_i     (prog_en_i),
    .shift_i  (phase == PH_SHIFT),
    .sdata_i  (ser_data_i),
    .stages_o (stages)
  );

  fpc_ctrl_reg #(.NUM_OUT(NUM_OUT)) u_ctrl (
    .clk_i    (prog_clk_i),
    .en_i     (prog_en_i),
    .commit_i (phase == PH_COMMIT),
    .stages_i (stages),
    .oe_o     (reg_oe),
    .sel_o    (reg_sel)
  );

  // enable low: bypass the register, serial line picks the clock live
  always_comb begin
    if (prog_en_i) begin
      oe_o      = reg_oe;
      clk_sel_o = reg_sel;
    end else begin
      oe_o      = '1;
      clk_sel_o = ser_data_i;
    end
  end
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int unsigned NUM_OUT = 10
) (
  input logic               prog_clk_i,
  input logic               prog_en_i,
  input logic               ser_data_i,
  input logic [NUM_OUT-1:0] oe_o,
  input logic               clk_sel_o
);
  localparam int unsigned WORD_W = NUM_OUT + 1;
  localparam int unsigned SEQ    = WORD_W + 1;
  localparam int unsigned CW     = $clog2(SEQ + 1);
  localparam logic [CW-1:0] SEQ_C  = CW'(SEQ);
  localparam logic [CW-1:0] LAST_C = CW'(SEQ - 1);
  localparam logic [CW-1:0] WORD_C = CW'(WORD_W);

  logic [CW-1:0]     edges_q;
  logic [WORD_W-1:0] shadow_q;

  always_ff @(posedge prog_clk_i or negedge prog_en_i) begin
    if (!prog_en_i) begin
      edges_q  <= '0;
      shadow_q <= '0;
    end else begin
      if (edges_q < WORD_C) shadow_q[edges_q] <= ser_data_i;
      if (edges_q != SEQ_C) edges_q <= edges_q + 1'b1;
    end
  end

  function automatic logic [NUM_OUT-1:0] rev_en(input logic [WORD_W-1:0] w);
    for (int k = 0; k < NUM_OUT; k++) rev_en[NUM_OUT-1-k] = w[k];
  endfunction

  // R4 R5
  pre_commit_default_chk: assert property (@(posedge prog_clk_i) disable iff (!prog_en_i)
    (edges_q < SEQ_C) |-> (oe_o == '1 && !clk_sel_o));

  // R1 R2 R3
  commit_word_chk: assert property (@(posedge prog_clk_i) disable iff (!prog_en_i)
    (edges_q == LAST_C) |=> (oe_o == rev_en(shadow_q) && clk_sel_o == shadow_q[WORD_W-1]));

  // R7
  post_commit_hold_chk: assert property (@(posedge prog_clk_i) disable iff (!prog_en_i)
    (edges_q == SEQ_C) |=> ($stable(oe_o) && $stable(clk_sel_o)));

  // R6
  bypass_chk: assert property (@(posedge prog_clk_i)
    !prog_en_i |-> (oe_o == '1 && clk_sel_o == ser_data_i));
endmodule

bind fanout_prog_ctrl fpc_chk #(.NUM_OUT(NUM_OUT)) u_fpc_chk (
  .prog_clk_i (prog_clk_i),
  .prog_en_i  (prog_en_i),
  .ser_data_i (ser_data_i),
  .oe_o       (oe_o),
  .clk_sel_o  (clk_sel_o)
);

// File: tb/fanout_prog_ctrl_bench.sv
`timescale 1ns/1ps
module fanout_prog_ctrl_bench;
  localparam int NO = 10;
  localparam int WW = NO + 1;

  logic          clk = 1'b0;
  logic          en  = 1'b0;
  logic          si  = 1'b0;
  logic [NO-1:0] oe;
  logic          sel;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fanout_prog_ctrl #(.NUM_OUT(NO)) u_fanout_prog_ctrl (
    .prog_clk_i (clk),
    .prog_en_i  (en),
    .ser_data_i (si),
    .oe_o       (oe),
    .clk_sel_o  (sel)
  );

  // expected {sel, oe} for a committed word: bit k -> oe[9-k], bit 10 -> sel
  function automatic logic [WW-1:0] exp_of(input logic [WW-1:0] w);
    logic [WW-1:0] r;
    r[WW-1] = w[WW-1];
    for (int k = 0; k < NO; k++) r[NO-1-k] = w[k];
    return r;
  endfunction

  function automatic logic [WW-1:0] dflt(input logic s);
    return {s, {NO{1'b1}}};
  endfunction

  task automatic chk(input string rq, input logic [WW-1:0] expv);
    checks++;
    if ({sel, oe} !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", rq, {sel, oe}, expv);
    end
  endtask

  // raise enable at a negedge with bit 0 presented, then shift n_edges edges
  task automatic run_seq(input logic [WW-1:0] w, input int n_edges);
    @(negedge clk);
    en = 1'b1;
    si = w[0];
    #1 chk("R5 default after enable rise", dflt(1'b0));
    for (int k = 1; k <= n_edges && k <= WW; k++) begin
      @(negedge clk);
      #1 chk("R4 no commit before twelfth edge", dflt(1'b0));
      si = (k < WW) ? w[k] : 1'($urandom);
    end
  endtask

  task automatic full_prog(input logic [WW-1:0] w, input int extra);
    logic [WW-1:0] e;
    e = exp_of(w);
    run_seq(w, WW);
    @(negedge clk);
    #1 chk("R1 R2 R3 R4 commit on twelfth edge", e);
    for (int n = 0; n < extra; n++) begin
      si = 1'($urandom);
      @(negedge clk);
      #1 chk("R7 edges after commit ignored", e);
    end
  endtask

  task automatic drop_en();
    @(negedge clk);
    en = 1'b0;
    si = 1'b0;
    #1 chk("R6 bypass select 0", dflt(1'b0));
    si = 1'b1;
    #1 chk("R6 bypass select follows live", dflt(1'b1));
    @(negedge clk);
    #1 chk("R6 bypass holds across edge", dflt(1'b1));
    si = 1'b0;
    #1 chk("R6 bypass select back to 0", dflt(1'b0));
  endtask

  initial begin
    void'($urandom(32'h0bad5eed));
    #1 chk("R6 reset state", dflt(1'b0));
    drop_en();
    // directed corners
    full_prog(11'b000_0000_0001, 3);  // R2 bit0 -> oe[9]
    drop_en();
    full_prog(11'b100_0000_0000, 2);  // R3 select only, all disabled
    drop_en();
    full_prog(11'b011_1111_1111, 2);
    drop_en();
    full_prog(11'b101_0101_0110, 4);
    // R5: re-rise after a commit restarts at default (checked inside run_seq)
    drop_en();
    // R8: abort after 5 edges, restart with a new word
    run_seq(11'b111_1111_0000, 5);
    drop_en();
    full_prog(11'b110_0011_1001, 2);  // R8 fresh count
    drop_en();
    // random words
    for (int t = 0; t < 40; t++) begin
      full_prog(11'($urandom), 1 + int'($urandom % 4));
      if (($urandom % 3) == 0) begin
        drop_en();
      end else begin
        @(negedge clk);
        en = 1'b0;
        #1 chk("R6 bypass after random word", dflt(si));
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule